// File: doc/BRIEF.md
# Thermostat Alert with Fault Queue

This block watches a stream of finished 12-bit two's-complement temperature results and decides when a thermal alert is raised and released. Each result arrives with a one-cycle conversion-done strobe and is compared, as a signed value, against a programmable upper limit and a programmable lower limit. A fault queue filters out noise: the state changes only after a chosen number of consecutive qualifying results.

Two alert behaviours run side by side. The comparator behaviour has hysteresis: it sets at or above the upper limit and releases below the lower limit. The interrupt behaviour latches one event. After a latched event is cleared, it watches the opposite limit, so upper and lower events alternate. A clear comes from any register read, a successful alert-response handshake, or shutdown. A mode input picks which behaviour drives the alert pin. A polarity input sets the active level of both the pin and the status bit. A flag reports which limit caused the pending alert, for use by the alert-response logic.

Top module: `therm_alert`

## Requirements
- R1: `fault_sel_i` sets how many consecutive qualifying results are needed: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4, 2'b11 needs 6.
- R2: When the comparator state is inactive, it becomes active after the required number of consecutive strobed results that are greater than or equal to `t_high_i`.
- R3: When the comparator state is active, it becomes inactive after the required number of consecutive strobed results that are below `t_low_i`. A result equal to `t_low_i` does not count.
- R4: A fault count advances only in a cycle where `conv_done_i` is high. Idle cycles between strobes leave it unchanged. A strobed result that does not meet the watched condition resets it to zero.
- R5: In interrupt mode (`int_mode_i`=1), a qualified event sets a pending alert. The pending alert stays set, and further results are ignored, until `reg_read_i`, `ara_ack_i` or `shutdown_i` is high at a clock edge.
- R6: The interrupt path starts out watching the upper limit. Each clear of a pending alert swaps the watched condition: from "result >= `t_high_i`" to "result < `t_low_i`", or back again.
- R7: The active alert is the pending interrupt when `int_mode_i`=1 and the comparator state when it is 0. `alert_o` is low when that alert is active if `polarity_i`=0, and high when it is active if `polarity_i`=1.
- R8: `status_o` equals the comparator state XOR `polarity_i`, whatever `int_mode_i` is.
- R9: All `TEMP_W` bits of the result and both limits take part in the comparison, and the comparison is signed. For example, 12'h000 is at or above 12'hFF0.
- R10: After reset the comparator state is inactive, no interrupt is pending, the interrupt path watches the upper limit, and both fault counts are zero.
- R11: In interrupt mode, `high_src_o` is 1 if the pending alert came from the upper limit and 0 if it came from the lower limit. In comparator mode it equals the comparator state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle strobe: `result_i` holds a finished conversion |
| result_i | input | TEMP_W | Conversion result, two's complement |
| t_high_i | input | TEMP_W | Upper limit, two's complement |
| t_low_i | input | TEMP_W | Lower limit, two's complement |
| fault_sel_i | input | 2 | Consecutive-fault count select |
| int_mode_i | input | 1 | 0 comparator mode, 1 interrupt mode |
| polarity_i | input | 1 | 0 active-low alert, 1 active-high alert |
| reg_read_i | input | 1 | Pulse on any register read |
| ara_ack_i | input | 1 | Pulse on a successful alert-response handshake |
| shutdown_i | input | 1 | Shutdown bit |
| alert_o | output | 1 | Alert pin level |
| status_o | output | 1 | Comparator status bit, polarity applied |
| high_src_o | output | 1 | Alert source flag: 1 upper limit, 0 lower limit |

## Verification
Some rules hold on every cycle, and the bound checker tests those: the comparator state does not move without a strobe, a one-fault setting sets the state on the first strobed high result, a pending interrupt is held until a clear and drops on one, each clear swaps the watched limit, and a new pending alert always follows a strobe. The bench scenarios are needed for the rest. They cover the exact count each fault setting needs, hysteresis across the gap between the limits, and the reset of the count on equality with the lower limit. They also cover the full upper-lower-upper interrupt cycle with each clear source, and the signed ordering of negative values.

// File: rtl/therm_alert_pkg.sv
package therm_alert_pkg;

  typedef enum logic [1:0] {
    FQ_ONE  = 2'b00,
    FQ_TWO  = 2'b01,
    FQ_FOUR = 2'b10,
    FQ_SIX  = 2'b11
  } fault_sel_e;

  localparam int unsigned NUM_PATHS = 2;
  localparam int unsigned PATH_CMP  = 0;
  localparam int unsigned PATH_INT  = 1;

  // R1: consecutive results required per fault select code
  function automatic int unsigned fault_need(input logic [1:0] sel);
    case (fault_sel_e'(sel))
      FQ_ONE:  return 1;
      FQ_TWO:  return 2;
      FQ_FOUR: return 4;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/therm_limit_cmp.sv
module therm_limit_cmp #(
  parameter int TEMP_W = 12
) (
  input  logic [TEMP_W-1:0] result_i,
  input  logic [TEMP_W-1:0] t_high_i,
  input  logic [TEMP_W-1:0] t_low_i,
  output logic              ge_high_o,
  output logic              lt_low_o
);
  // full-width signed compare, independent of converter resolution
  assign ge_high_o = $signed(result_i) >= $signed(t_high_i);
  assign lt_low_o  = $signed(result_i) <  $signed(t_low_i);
endmodule

// File: rtl/therm_fault_queue.sv
module therm_fault_queue #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             hit_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             qualify_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc   = cnt_q + 1'b1;
  assign qualify_o = strobe_i & hit_i & ~hold_i & (cnt_inc == need_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hold_i) begin
      cnt_q <= '0;
    end else if (strobe_i) begin
      cnt_q <= (hit_i && !qualify_o) ? cnt_inc : '0;
    end
  end
endmodule

// File: rtl/therm_int_latch.sv
module therm_int_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qualify_i,
  input  logic clear_i,
  output logic pend_o,
  output logic watch_low_o,
  output logic src_high_o
);
  logic pend_q, watch_low_q, src_high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      watch_low_q <= 1'b0;
      src_high_q  <= 1'b0;
    end else if (pend_q && clear_i) begin
      pend_q      <= 1'b0;
      watch_low_q <= ~watch_low_q;
    end else if (!pend_q && qualify_i) begin
      pend_q     <= 1'b1;
      src_high_q <= ~watch_low_q;
    end
  end

  assign pend_o      = pend_q;
  assign watch_low_o = watch_low_q;
  assign src_high_o  = src_high_q;
endmodule

// File: rtl/therm_alert.sv
module therm_alert
  import therm_alert_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [TEMP_W-1:0] result_i,
  input  logic [TEMP_W-1:0] t_high_i,
  input  logic [TEMP_W-1:0] t_low_i,
  input  logic [1:0]        fault_sel_i,
  input  logic              int_mode_i,
  input  logic              polarity_i,
  input  logic              reg_read_i,
  input  logic              ara_ack_i,
  input  logic              shutdown_i,
  output logic              alert_o,
  output logic              status_o,
  output logic              high_src_o
);
  logic             ge_high, lt_low;
  logic [CNT_W-1:0] need;
  logic             cmp_q;
  logic             int_pend, watch_low, int_src_high;
  logic             int_clear;
  logic             active;

  logic [NUM_PATHS-1:0] path_hit, path_hold, path_qual;

  therm_limit_cmp #(.TEMP_W(TEMP_W)) i_limit_cmp (
    .result_i  (result_i),
    .t_high_i  (t_high_i),
    .t_low_i   (t_low_i),
    .ge_high_o (ge_high),
    .lt_low_o  (lt_low)
  );

  assign need = CNT_W'(fault_need(fault_sel_i));

  // each path watches the opposite limit once its state is set
  assign path_hit[PATH_CMP]  = cmp_q     ? lt_low : ge_high;
  assign path_hold[PATH_CMP] = 1'b0;
  assign path_hit[PATH_INT]  = watch_low ? lt_low : ge_high;
  assign path_hold[PATH_INT] = int_pend;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_queue
    therm_fault_queue #(.CNT_W(CNT_W)) i_fault_queue (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strobe_i  (conv_done_i),
      .hit_i     (path_hit[p]),
      .hold_i    (path_hold[p]),
      .need_i    (need),
      .qualify_o (path_qual[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cmp_q <= 1'b0;
    else if (path_qual[PATH_CMP]) cmp_q <= ~cmp_q;
  end

  assign int_clear = reg_read_i | ara_ack_i | shutdown_i;

  therm_int_latch i_int_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .qualify_i   (path_qual[PATH_INT]),
    .clear_i     (int_clear),
    .pend_o      (int_pend),
    .watch_low_o (watch_low),
    .src_high_o  (int_src_high)
  );

  assign active     = int_mode_i ? int_pend : cmp_q;
  assign alert_o    = ~(active ^ polarity_i);
  assign status_o   = cmp_q ^ polarity_i;
  assign high_src_o = int_mode_i ? int_src_high : cmp_q;

endmodule

// File: rtl/therm_alert_chk.sv
module therm_alert_chk #(
  parameter int TEMP_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_done_i,
  input logic [TEMP_W-1:0] result_i,
  input logic [TEMP_W-1:0] t_high_i,
  input logic [1:0]        fault_sel_i,
  input logic              reg_read_i,
  input logic              ara_ack_i,
  input logic              shutdown_i,
  input logic              cmp_q,
  input logic              int_pend,
  input logic              watch_low
);
  logic clr;
  assign clr = reg_read_i | ara_ack_i | shutdown_i;

  assert_no_move_without_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> $stable(cmp_q));

  assert_single_fault_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && fault_sel_i == 2'b00 && !cmp_q &&
     $signed(result_i) >= $signed(t_high_i)) |=> cmp_q);

  assert_pend_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_pend && !clr) |=> int_pend);

  assert_pend_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_pend && clr) |=> !int_pend);

  assert_watch_swaps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_pend && clr) |=> (watch_low != $past(watch_low)));

  assert_pend_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_pend) |-> $past(conv_done_i));
endmodule

bind therm_alert therm_alert_chk #(.TEMP_W(TEMP_W)) i_therm_alert_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_done_i (conv_done_i),
  .result_i    (result_i),
  .t_high_i    (t_high_i),
  .fault_sel_i (fault_sel_i),
  .reg_read_i  (reg_read_i),
  .ara_ack_i   (ara_ack_i),
  .shutdown_i  (shutdown_i),
  .cmp_q       (cmp_q),
  .int_pend    (int_pend),
  .watch_low   (watch_low)
);

// File: tb/test_therm_alert.sv
`timescale 1ns/1ps
module test_therm_alert;
  localparam int TEMP_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              conv_done = 1'b0;
  logic [TEMP_W-1:0] result = '0;
  logic [TEMP_W-1:0] t_high = 12'h500;
  logic [TEMP_W-1:0] t_low  = 12'h4B0;
  logic [1:0]        fault_sel = 2'b00;
  logic              int_mode = 1'b0;
  logic              polarity = 1'b0;
  logic              reg_read = 1'b0;
  logic              ara_ack = 1'b0;
  logic              shutdown = 1'b0;
  logic              alert, status, high_src;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  therm_alert #(.TEMP_W(TEMP_W)) i_therm_alert (
    .clk_i(clk), .rst_ni(rst_n), .conv_done_i(conv_done), .result_i(result),
    .t_high_i(t_high), .t_low_i(t_low), .fault_sel_i(fault_sel),
    .int_mode_i(int_mode), .polarity_i(polarity), .reg_read_i(reg_read),
    .ara_ack_i(ara_ack), .shutdown_i(shutdown),
    .alert_o(alert), .status_o(status), .high_src_o(high_src)
  );

  // {expected comparator state, result}; limits 0x500/0x4B0, two faults needed
  localparam logic [12:0] VEC [10] = '{
    {1'b0, 12'h400}, {1'b0, 12'h500}, {1'b0, 12'h4C0}, {1'b0, 12'h600},
    {1'b1, 12'h7FF}, {1'b1, 12'h4AF}, {1'b1, 12'h4B0}, {1'b1, 12'hC90},
    {1'b0, 12'h800}, {1'b0, 12'h500}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    conv_done = 0; reg_read = 0; ara_ack = 0; shutdown = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic strobe(input logic [TEMP_W-1:0] r);
    result = r; conv_done = 1;
    @(negedge clk);
    conv_done = 0;
  endtask

  task automatic pulse_read();  reg_read = 1; @(negedge clk); reg_read = 0; endtask
  task automatic pulse_ara();   ara_ack  = 1; @(negedge clk); ara_ack  = 0; endtask
  task automatic pulse_sd();    shutdown = 1; @(negedge clk); shutdown = 0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state, polarity 0
    chk("R10 alert idle", alert, 1'b1);
    chk("R10 status idle", status, 1'b0);
    chk("R10 high_src idle", high_src, 1'b0);

    // table walk: R2 R3 R4 hysteresis, comparator mode
    fault_sel = 2'b01;
    for (int i = 0; i < 10; i++) begin
      strobe(VEC[i][11:0]);
      chk($sformatf("R3 vec%0d status", i), status, VEC[i][12]);
      chk($sformatf("R7 vec%0d alert", i), alert, ~VEC[i][12]);
    end

    // R1: exact count per fault select
    for (int s = 0; s < 4; s++) begin
      int n;
      do_reset();
      fault_sel = 2'(s);
      n = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 6;
      for (int k = 0; k < n - 1; k++) strobe(12'h600);
      chk($sformatf("R1 sel%0d short", s), status, 1'b0);
      strobe(12'h600);
      chk($sformatf("R1 sel%0d full", s), status, 1'b1);
    end

    // R4: no strobe no count; idle gaps keep count
    do_reset();
    fault_sel = 2'b01;
    result = 12'h700;
    repeat (5) @(negedge clk);
    chk("R4 no strobe", status, 1'b0);
    strobe(12'h700);
    repeat (4) @(negedge clk);
    chk("R4 one of two", status, 1'b0);
    strobe(12'h700);
    chk("R4 gap kept count", status, 1'b1);

    // R9: signed compare
    do_reset();
    fault_sel = 2'b00;
    t_high = 12'hFF0; t_low = 12'hF00;
    strobe(12'h000);
    chk("R9 zero above negative high", status, 1'b1);
    strobe(12'hF00);
    chk("R9 equal low not below", status, 1'b1);
    strobe(12'hEFF);
    chk("R9 more negative below low", status, 1'b0);
    t_high = 12'h500; t_low = 12'h4B0;

    // R5 R6 R11 interrupt cycle
    do_reset();
    int_mode = 1; fault_sel = 2'b00;
    strobe(12'h600);
    chk("R5 high event alert", alert, 1'b0);
    chk("R11 src high", high_src, 1'b1);
    chk("R8 status in int mode", status, 1'b1);
    strobe(12'h100);
    chk("R5 held while pending", alert, 1'b0);
    chk("R8 status follows comparator", status, 1'b0);
    pulse_read();
    chk("R5 read clears", alert, 1'b1);
    strobe(12'h600);
    chk("R6 high ignored after clear", alert, 1'b1);
    strobe(12'h100);
    chk("R6 low event alert", alert, 1'b0);
    chk("R11 src low", high_src, 1'b0);
    pulse_ara();
    chk("R5 ara clears", alert, 1'b1);
    strobe(12'h100);
    chk("R6 low ignored after clear", alert, 1'b1);
    strobe(12'h600);
    chk("R6 high watched again", alert, 1'b0);
    chk("R11 src high again", high_src, 1'b1);
    pulse_sd();
    chk("R5 shutdown clears", alert, 1'b1);

    // R7 R8 polarity
    do_reset();
    int_mode = 0; polarity = 1; fault_sel = 2'b00;
    @(negedge clk);
    chk("R7 pol1 idle alert", alert, 1'b0);
    chk("R8 pol1 idle status", status, 1'b1);
    strobe(12'h600);
    chk("R7 pol1 active alert", alert, 1'b1);
    chk("R8 pol1 active status", status, 1'b0);
    chk("R11 comparator src", high_src, 1'b1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule